// File: doc/BRIEF.md
# Four-Channel Prescaled Pulse Width Modulator

This block generates four independent pulse-width-modulated outputs from one clock. A small word-addressed read/write port reaches one shared control word and one configuration word per channel. The control word holds a run bit and a two-bit clock-ratio code for every channel. Each configuration word holds a period length and a high-time length. Both lengths are counted in steps, and a step is a whole number of clock cycles fixed by the ratio code.

Each channel builds its step ticks from two bypassable sub-dividers in series, one dividing by 8 and one dividing by 64. This gives step lengths of 1, 8, 64 or 512 cycles. A period counter walks through the steps, and the output is high during the leading steps of every period. Period and high-time values written while a channel runs are held back until the current period ends, so no period is ever cut short or stretched.

Top module: `stepdiv_pwm`

## Requirements
- R1: Byte addresses are decoded by word, and the two lowest address bits are ignored. Word 0 is the control word: bit n (n = 0..3) is channel n's run bit, and bits [2n+5:2n+4] are channel n's ratio code. Word n+1 is channel n's configuration word, with the period count in bits [15:0] and the high count in bits [31:16]. Every register reads back the value last written to it, and control bits [31:12] always read zero.
- R2: Reset clears every register to zero and drives every output low.
- R3: A running channel repeats a period of P steps, where P is its period count. Its output is high during the first H steps of each period, where H is its high count, and low during the rest.
- R4: Ratio code 0 gives one clock cycle per step, code 1 gives 8, code 2 gives 64 and code 3 gives 512.
- R5: Suppose a write sets a run bit at clock edge k. The channel's output stays low until edge k+1, and the first step of a fresh period begins at edge k+1.
- R6: While its run bit is zero, a channel's output is low, starting from the edge that clears the bit. Setting the bit again restarts both the step divider and the period count from zero.
- R7: Period or high counts written while a channel runs take effect only at the start of the next period.
- R8: The four channels run independently. Writing one channel's configuration word does not change another channel's output.
- R9: A high count of zero keeps the output low. A high count equal to or greater than the period count keeps the output high.
- R10: A write to a word index above 4 changes no register, and a read from such an index returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_addr | input | 5 | Byte address of the register being accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pwm_out | output | 4 | One pulse output per channel |

## Verification
The assertions assume that the address and the write strobe are steady around each rising edge, and that a write strobe lasts exactly one cycle for each intended write. The bench meets this by changing these inputs only on falling edges and by dropping the strobe right after the edge that takes the write. The waveform checks also rely on each channel being stopped before it is reconfigured and then started with a single control write. The bench therefore clears the whole control word before it loads new configuration words. Only the update-during-run scenario breaks that rule, and it does so on purpose, with a write placed in the middle of a period.

// File: rtl/stepdiv_pwm_pkg.sv
package stepdiv_pwm_pkg;

   localparam int WORD_W  = 32;
   localparam int FIELD_W = 16;
   localparam int SEL_LSB = 4;

   typedef struct packed {
      logic [FIELD_W-1:0] duty;
      logic [FIELD_W-1:0] tbase;
   } chan_cfg_t;

   typedef enum logic [1:0] {
      PS_DIV1   = 2'd0,
      PS_DIVA   = 2'd1,
      PS_DIVB   = 2'd2,
      PS_DIVAB  = 2'd3
   } psel_e;

endpackage

// File: rtl/stepdiv_pwm_regfile.sv
module stepdiv_pwm_regfile
   import stepdiv_pwm_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int ADDR_W = 5,
   localparam int IDX_W = ADDR_W - 2,
   localparam int SEL_W = 2 * NUM_CH
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [ADDR_W-1:0]        addr,
   input  logic [WORD_W-1:0]        wdata,
   output logic [WORD_W-1:0]        rdata,
   output logic [NUM_CH-1:0]        en_o,
   output logic [SEL_W-1:0]         sel_o,
   output chan_cfg_t [NUM_CH-1:0]   cfg_o
);

   logic [IDX_W-1:0]       widx;
   logic                   unused_byte_lanes;
   logic [NUM_CH-1:0]      en_q;
   logic [SEL_W-1:0]       sel_q;
   chan_cfg_t [NUM_CH-1:0] cfg_q;

   assign widx              = addr[ADDR_W-1:2];
   assign unused_byte_lanes = ^addr[1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= '0;
         sel_q <= '0;
         cfg_q <= '0;
      end else if (wr_en) begin
         if (widx == '0) begin
            en_q  <= wdata[NUM_CH-1:0];
            sel_q <= wdata[SEL_LSB +: SEL_W];
         end
         for (int n = 0; n < NUM_CH; n++) begin
            if (widx == IDX_W'(n + 1)) cfg_q[n] <= chan_cfg_t'(wdata);
         end
      end
   end

   always_comb begin
      rdata = '0;
      if (widx == '0) begin
         rdata[NUM_CH-1:0]         = en_q;
         rdata[SEL_LSB +: SEL_W]   = sel_q;
      end
      for (int n = 0; n < NUM_CH; n++) begin
         if (widx == IDX_W'(n + 1)) rdata = cfg_q[n];
      end
   end

   assign en_o  = en_q;
   assign sel_o = sel_q;
   assign cfg_o = cfg_q;

endmodule

// File: rtl/stepdiv_pwm_divstage.sv
module stepdiv_pwm_divstage #(
   parameter int DIV = 8,
   localparam int CW = (DIV > 1) ? $clog2(DIV) : 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic bypass,
   input  logic tick_in,
   output logic tick_out
);

   generate
      if (DIV > 1) begin : g_count
         logic [CW-1:0] cnt_q;
         logic          last;

         assign last = (cnt_q == CW'(DIV - 1));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                cnt_q <= '0;
            else if (clr || bypass)    cnt_q <= '0;
            else if (tick_in)          cnt_q <= last ? '0 : cnt_q + CW'(1);
         end

         assign tick_out = bypass ? tick_in : (tick_in && last);
      end else begin : g_wire
         logic unused_stage;
         assign unused_stage = clk ^ rst_n ^ clr ^ bypass;
         assign tick_out     = tick_in;
      end
   endgenerate

endmodule

// File: rtl/stepdiv_pwm_chan.sv
module stepdiv_pwm_chan
   import stepdiv_pwm_pkg::*;
#(
   parameter int CNT_W = 16,
   parameter int DIV_A = 8,
   parameter int DIV_B = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [1:0]       sel,
   input  logic [CNT_W-1:0] cfg_tbase,
   input  logic [CNT_W-1:0] cfg_duty,
   output logic             pwm
);

   logic             running_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] tb_q;
   logic [CNT_W-1:0] duty_q;
   logic             tick_a;
   logic             step;
   logic             wrap;
   psel_e            mode;

   assign mode = psel_e'(sel);

   stepdiv_pwm_divstage #(.DIV(DIV_A)) u_div_a (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (!running_q),
      .bypass   (!(mode == PS_DIVA || mode == PS_DIVAB)),
      .tick_in  (1'b1),
      .tick_out (tick_a)
   );

   stepdiv_pwm_divstage #(.DIV(DIV_B)) u_div_b (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (!running_q),
      .bypass   (!(mode == PS_DIVB || mode == PS_DIVAB)),
      .tick_in  (tick_a),
      .tick_out (step)
   );

   assign wrap = (tb_q == '0) || (cnt_q == tb_q - CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running_q <= 1'b0;
         cnt_q     <= '0;
         tb_q      <= '0;
         duty_q    <= '0;
      end else if (!en) begin
         running_q <= 1'b0;
         cnt_q     <= '0;
      end else if (!running_q) begin
         running_q <= 1'b1;
         cnt_q     <= '0;
         tb_q      <= cfg_tbase;
         duty_q    <= cfg_duty;
      end else if (step) begin
         if (wrap) begin
            cnt_q  <= '0;
            tb_q   <= cfg_tbase;
            duty_q <= cfg_duty;
         end else begin
            cnt_q  <= cnt_q + CNT_W'(1);
         end
      end
   end

   assign pwm = en && running_q && (cnt_q < duty_q);

endmodule

// File: rtl/stepdiv_pwm.sv
module stepdiv_pwm
   import stepdiv_pwm_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int CNT_W  = 16,
   parameter int ADDR_W = 5,
   parameter int DIV_A  = 8,
   parameter int DIV_B  = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic [NUM_CH-1:0] pwm_out
);

   localparam int SEL_W = 2 * NUM_CH;

   generate
      if (NUM_CH < 1 || NUM_CH > 4) begin : g_bad_ch
         $error("stepdiv_pwm: NUM_CH must lie in 1..4");
      end
      if (CNT_W < 1 || CNT_W > FIELD_W) begin : g_bad_cnt
         $error("stepdiv_pwm: CNT_W must lie in 1..FIELD_W");
      end
      if ((NUM_CH + 1) > (1 << (ADDR_W - 2))) begin : g_bad_addr
         $error("stepdiv_pwm: ADDR_W too small for the register count");
      end
      if (DIV_A < 1 || DIV_B < 1) begin : g_bad_div
         $error("stepdiv_pwm: divider ratios must be positive");
      end
   endgenerate

   logic [NUM_CH-1:0]      ctrl_en;
   logic [SEL_W-1:0]       ctrl_sel;
   chan_cfg_t [NUM_CH-1:0] ch_cfg;

   stepdiv_pwm_regfile #(
      .NUM_CH (NUM_CH),
      .ADDR_W (ADDR_W)
   ) u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (bus_we),
      .addr  (bus_addr),
      .wdata (bus_wdata),
      .rdata (bus_rdata),
      .en_o  (ctrl_en),
      .sel_o (ctrl_sel),
      .cfg_o (ch_cfg)
   );

   generate
      for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
         stepdiv_pwm_chan #(
            .CNT_W (CNT_W),
            .DIV_A (DIV_A),
            .DIV_B (DIV_B)
         ) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .en        (ctrl_en[n]),
            .sel       (ctrl_sel[2*n +: 2]),
            .cfg_tbase (ch_cfg[n].tbase[CNT_W-1:0]),
            .cfg_duty  (ch_cfg[n].duty[CNT_W-1:0]),
            .pwm       (pwm_out[n])
         );
      end
   endgenerate

endmodule

module stepdiv_pwm_chk #(
   parameter int NUM_CH = 4,
   parameter int ADDR_W = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_we,
   input logic [ADDR_W-3:0] widx,
   input logic [NUM_CH-1:0] wen_bits,
   input logic [31:0]       bus_rdata,
   input logic [NUM_CH-1:0] en_vec,
   input logic [NUM_CH-1:0] pwm_out
);

   localparam int TOP_LSB = 4 + 2 * NUM_CH;

   // R1: a control write lands in the run bits on the next edge
   a_r1_run_bits_written: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && widx == '0) |=> (en_vec == $past(wen_bits)));

   // R1: control word upper bits read zero
   a_r1_ctrl_top_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (widx == '0) |-> (bus_rdata[31:TOP_LSB] == '0));

   // R10: unmapped words read zero
   a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (widx > (ADDR_W-2)'(NUM_CH)) |-> (bus_rdata == '0));

   // R6: a stopped channel is low
   a_r6_stopped_low: assert property (@(posedge clk) disable iff (!rst_n)
      ((pwm_out & ~en_vec) == '0));

   // R5: in the cycle a run bit rises the output is still low
   a_r5_start_low: assert property (@(posedge clk) disable iff (!rst_n)
      ((en_vec & ~$past(en_vec) & pwm_out) == '0));

endmodule

bind stepdiv_pwm stepdiv_pwm_chk #(
   .NUM_CH (NUM_CH),
   .ADDR_W (ADDR_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_we    (bus_we),
   .widx      (bus_addr[ADDR_W-1:2]),
   .wen_bits  (bus_wdata[NUM_CH-1:0]),
   .bus_rdata (bus_rdata),
   .en_vec    (ctrl_en),
   .pwm_out   (pwm_out)
);

// File: tb/sim_stepdiv_pwm.sv
`timescale 1ns/1ps
module sim_stepdiv_pwm;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [3:0]  pwm_out;

   int checks = 0;
   int errs = 0;

   int m_tb[4];
   int m_du[4];
   int m_sel[4];
   logic [3:0] m_en;

   always #2 clk = ~clk;

   stepdiv_pwm u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .pwm_out   (pwm_out)
   );

   function automatic int ratio(int sel);
      return (sel == 0) ? 1 : (sel == 1) ? 8 : (sel == 2) ? 64 : 512;
   endfunction

   function automatic logic wave_bit(int t, int tb, int du, int rt);
      int tbe = (tb == 0) ? 1 : tb;
      return ((t / rt) % tbe) < du;
   endfunction

   task automatic check_eq(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic bus_write(logic [4:0] a, logic [31:0] d);
      @(negedge clk);
      bus_addr  = a;
      bus_wdata = d;
      bus_we    = 1'b1;
      @(posedge clk);
      #1 bus_we = 1'b0;
   endtask

   task automatic bus_read_check(string tag, logic [4:0] a, logic [31:0] exp);
      @(negedge clk);
      bus_addr = a;
      #1 check_eq(tag, bus_rdata, exp);
   endtask

   task automatic start_all();
      logic [31:0] w;
      bus_write(5'h00, 32'h0);
      for (int c = 0; c < 4; c++)
         bus_write(5'(4 + 4 * c), {16'(m_du[c]), 16'(m_tb[c])});
      w = {28'h0, m_en};
      for (int c = 0; c < 4; c++) w |= 32'(m_sel[c]) << (2 * c + 4);
      bus_write(5'h00, w);
   endtask

   // Called right after the edge that set the run bits.
   task automatic run_wave(string tag, int ncyc, int upd_t, int upd_ch,
                           int n_tb, int n_du, int sw_t);
      int   bad[4];
      int   ft[4];
      logic fa[4];
      logic fe[4];
      logic e;
      for (int c = 0; c < 4; c++) bad[c] = 0;
      @(posedge clk);
      for (int t = 0; t < ncyc; t++) begin
         @(negedge clk);
         if (t == upd_t + 1) bus_we = 1'b0;
         for (int c = 0; c < 4; c++) begin
            if (!m_en[c]) e = 1'b0;
            else if (upd_t >= 0 && c == upd_ch && t >= sw_t)
               e = wave_bit(t - sw_t, n_tb, n_du, ratio(m_sel[c]));
            else
               e = wave_bit(t, m_tb[c], m_du[c], ratio(m_sel[c]));
            if (pwm_out[c] !== e) begin
               if (bad[c] == 0) begin ft[c] = t; fa[c] = pwm_out[c]; fe[c] = e; end
               bad[c]++;
            end
         end
         if (t == upd_t) begin
            bus_addr  = 5'(4 + 4 * upd_ch);
            bus_wdata = {16'(n_du), 16'(n_tb)};
            bus_we    = 1'b1;
         end
      end
      bus_we = 1'b0;
      for (int c = 0; c < 4; c++) begin
         checks++;
         if (bad[c] != 0) begin
            errs++;
            $display("FAIL %s ch%0d: cycle %0d actual=%b expected=%b (%0d mismatches)",
                     tag, c, ft[c], fa[c], fe[c], bad[c]);
         end
      end
   endtask

   task automatic t_reset();
      @(negedge clk);
      check_eq("R2 outputs after reset", 32'(pwm_out), 32'h0);
      for (int r = 0; r < 5; r++)
         bus_read_check("R2 register after reset", 5'(4 * r), 32'h0);
   endtask

   task automatic t_readback();
      bus_write(5'h00, 32'hFFFF_FFFF);
      bus_read_check("R1 control upper bits zero", 5'h00, 32'h0000_0FFF);
      bus_write(5'h00, 32'h0);
      for (int c = 0; c < 4; c++)
         bus_write(5'(4 + 4 * c), 32'hA500_0000 + 32'(c * 32'h0001_0111));
      for (int c = 0; c < 4; c++)
         bus_read_check("R1 config readback", 5'(4 + 4 * c),
                        32'hA500_0000 + 32'(c * 32'h0001_0111));
      bus_read_check("R1 low address bits ignored", 5'h07, 32'hA500_0000);
   endtask

   task automatic t_unmapped();
      bus_write(5'h18, 32'hDEAD_BEEF);
      bus_read_check("R10 unmapped read zero", 5'h18, 32'h0);
      bus_read_check("R10 control untouched", 5'h00, 32'h0);
      bus_read_check("R10 config untouched", 5'h04, 32'hA500_0000);
      @(negedge clk);
      check_eq("R10 outputs stay low", 32'(pwm_out), 32'h0);
   endtask

   task automatic t_all_ratios();
      m_tb  = '{5, 4, 3, 2};
      m_du  = '{2, 1, 2, 1};
      m_sel = '{0, 1, 2, 3};
      m_en  = 4'hF;
      start_all();
      run_wave("R3 R4 R8 four channels", 2200, -1, 0, 0, 0, 0);
   endtask

   task automatic t_extremes();
      m_tb  = '{6, 6, 6, 3};
      m_du  = '{0, 6, 9, 1};
      m_sel = '{0, 0, 0, 0};
      m_en  = 4'hF;
      start_all();
      run_wave("R9 zero and full high counts", 40, -1, 0, 0, 0, 0);
   endtask

   task automatic t_stop_restart();
      m_tb  = '{4, 0, 0, 0};
      m_du  = '{2, 0, 0, 0};
      m_sel = '{1, 0, 0, 0};
      m_en  = 4'h1;
      start_all();
      run_wave("R5 first run", 20, -1, 0, 0, 0, 0);
      bus_write(5'h00, 32'h0);
      check_eq("R6 low right after stop", 32'(pwm_out), 32'h0);
      repeat (5) @(negedge clk);
      check_eq("R6 stays low while stopped", 32'(pwm_out), 32'h0);
      bus_write(5'h00, 32'h0000_0011);
      run_wave("R6 fresh period on restart", 80, -1, 0, 0, 0, 0);
   endtask

   task automatic t_live_update();
      m_tb  = '{10, 0, 0, 3};
      m_du  = '{3, 0, 0, 1};
      m_sel = '{0, 0, 0, 0};
      m_en  = 4'h9;
      start_all();
      run_wave("R7 R8 update at period end", 60, 12, 0, 6, 4, 20);
   endtask

   initial begin
      #(4 * 100000);
      errs++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_readback();
      t_unmapped();
      t_all_ratios();
      t_extremes();
      t_stop_restart();
      t_live_update();
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

endmodule